// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block decides when an in-order core with two hardware thread contexts hands execution from one thread to the other. One context is in the foreground and issues instructions. The other waits in the background. Per-thread event pulses arrive from the rest of the core: short-latency misses (first-level data, first-level instruction, instruction address translation), long-latency misses (second-level data, second-level instruction, TLB), miss completion and instruction retirement. From these pulses the controller raises a one-cycle switch request and then flips the active-thread register.

The rules are these. A short miss hands over only when the waiting context is not itself stalled on a long miss. A long miss always hands over. A cycle budget forces a handover so that both threads get time. A per-thread forward-progress count stops the two threads from swapping back and forth without retiring anything. When the two priorities differ, the more important thread yields only on long misses and gets control back as soon as its miss completes. Every trigger can be masked on its own, and clearing a thread-enable bit gives single-thread operation. For each thread, the controller keeps the cause of the most recent switch away from that thread.

Top module: `thread_switch_ctl`

## Requirements
- R1: After reset, `active_thr` is 0, `sw_req` is 0 and both reason outputs are 0 (none).
- R2: A first-level data, first-level instruction or translation miss on the active thread raises `sw_req` one cycle later when the other thread has no outstanding long miss. The reason recorded for the thread that yields is then 1, 2 or 3 respectively.
- R3: A short miss on the active thread causes no switch while the other thread waits on a second-level or TLB miss.
- R4: A second-level data, second-level instruction or TLB miss on the active thread causes a switch whatever the other thread is waiting for. The recorded reason is 4, 5 or 6 respectively.
- R5: With a non-zero `timeout_lim` and the timeout enable bit set, a thread that has been active for `timeout_lim` cycles is switched out with reason 7. Consecutive forced switches are therefore `timeout_lim`+2 cycles apart.
- R6: Each thread has a count that increases on every switch and clears when that thread retires an instruction. While the active thread's count is above `fp_lim`, no switch is made.
- R7: With `cond_en` bit 6 set and unequal priorities, a higher-priority active thread ignores short misses and the timeout. When a higher-priority background thread's long miss completes, control returns to it, and reason 8 is recorded for the thread that yields.
- R8: `cond_en` bits mask triggers individually: bit 0 data miss, bit 1 instruction miss, bit 2 translation miss, bit 3 second-level data and TLB miss, bit 4 second-level instruction miss, bit 5 timeout, bit 6 priority. A masked trigger causes no switch.
- R9: No switch is made to a thread whose `thr_en` bit is clear.
- R10: `sw_req` is high for exactly one cycle. `active_thr` changes on the following cycle and at no other time, and the active-cycle count restarts from zero on that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_en | input | 2 | Per-thread enable |
| prio_t0 | input | 2 | Priority of thread 0 (larger is more important) |
| prio_t1 | input | 2 | Priority of thread 1 |
| cond_en | input | 7 | Per-trigger enable mask (see R8) |
| timeout_lim | input | TO_W (16) | Active-cycle budget, 0 disables |
| fp_lim | input | FP_W (4) | Forward-progress threshold |
| ev_dmiss | input | 2 | First-level data miss pulse per thread |
| ev_imiss | input | 2 | First-level instruction miss pulse per thread |
| ev_xmiss | input | 2 | Instruction translation miss pulse per thread |
| ev_l2d | input | 2 | Second-level data miss pulse per thread |
| ev_l2i | input | 2 | Second-level instruction miss pulse per thread |
| ev_tlb | input | 2 | TLB miss pulse per thread |
| ev_done | input | 2 | Outstanding long miss completed, per thread |
| ev_retire | input | 2 | Instruction retired, per thread |
| sw_req | output | 1 | One-cycle switch request |
| active_thr | output | 1 | Foreground thread |
| reason_t0 | output | 4 | Cause of last switch away from thread 0 |
| reason_t1 | output | 4 | Cause of last switch away from thread 1 |

## Verification
The same short-miss pulse is applied first with the background thread idle and then with it stalled on a TLB miss. This separates the guarded short-miss rule from the unconditional long-miss rule that follows it. A mask bit is cleared and a thread is disabled to show that the same miss then does nothing. The cycle budget is left to fire three times in a row, which shows its spacing. A low forward-progress threshold with repeated data misses shows the inhibit and its release on retirement. Unequal priorities show that short misses are ignored, a long miss hands over, and control comes straight back when the miss completes.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [3:0] {
        RSN_NONE    = 4'd0,
        RSN_L1D     = 4'd1,
        RSN_L1I     = 4'd2,
        RSN_XLAT    = 4'd3,
        RSN_L2D     = 4'd4,
        RSN_L2I     = 4'd5,
        RSN_TLB     = 4'd6,
        RSN_TIMEOUT = 4'd7,
        RSN_PRIO    = 4'd8
    } rsn_e;

    localparam int CE_L1D  = 0;
    localparam int CE_L1I  = 1;
    localparam int CE_XLAT = 2;
    localparam int CE_L2D  = 3;
    localparam int CE_L2I  = 4;
    localparam int CE_TMO  = 5;
    localparam int CE_PRIO = 6;
    localparam int CE_W    = 7;

    typedef struct packed {
        logic go;
        rsn_e why;
    } sw_dec_s;

    function automatic logic any_long(input logic l2d, input logic l2i, input logic tlb);
        return l2d | l2i | tlb;
    endfunction

endpackage

// File: rtl/tsw_thread_state.sv
module tsw_thread_state #(
    parameter int FP_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_long,
    input  logic            clr_long,
    input  logic            bump,
    input  logic            retire,
    output logic            long_wait,
    output logic [FP_W-1:0] fp_cnt
);
    localparam logic [FP_W-1:0] FP_MAX = {FP_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            long_wait <= 1'b0;
            fp_cnt    <= '0;
        end else begin
            if (set_long)
                long_wait <= 1'b1;
            else if (clr_long)
                long_wait <= 1'b0;
            if (retire)
                fp_cnt <= '0;
            else if (bump && fp_cnt != FP_MAX)
                fp_cnt <= fp_cnt + 1'b1;
        end
    end

    // R6: retirement resets forward-progress count
    assert_fp_clear_R6: assert property (@(posedge clk) disable iff (rst)
        retire |=> fp_cnt == '0);

endmodule

// File: rtl/tsw_timer.sv
module tsw_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    output logic [TO_W-1:0] cnt
);
    localparam logic [TO_W-1:0] CNT_MAX = {TO_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    // R5: the count saturates rather than wrapping
    assert_tmr_sat_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

endmodule

// File: rtl/tsw_decide.sv
module tsw_decide
    import tsw_pkg::*;
#(
    parameter int TO_W = 16,
    parameter int FP_W = 4
) (
    input  logic [CE_W-1:0] cond_en,
    input  logic            bg_en,
    input  logic [1:0]      prio_fg,
    input  logic [1:0]      prio_bg,
    input  logic            bg_long,
    input  logic            fg_l1d,
    input  logic            fg_l1i,
    input  logic            fg_xlat,
    input  logic            fg_l2d,
    input  logic            fg_l2i,
    input  logic            fg_tlb,
    input  logic            bg_done,
    input  logic [TO_W-1:0] to_cnt,
    input  logic [TO_W-1:0] to_lim,
    input  logic [FP_W-1:0] fp_fg,
    input  logic [FP_W-1:0] fp_lim,
    input  logic            busy,
    output sw_dec_s         dec
);
    logic fg_hi, bg_hi, short_ok, tmo_hit, prio_back;
    rsn_e why;

    always_comb begin
        fg_hi     = cond_en[CE_PRIO] && (prio_fg > prio_bg);
        bg_hi     = cond_en[CE_PRIO] && (prio_bg > prio_fg);
        short_ok  = !bg_long && !fg_hi;
        prio_back = bg_hi && bg_long && bg_done;
        tmo_hit   = cond_en[CE_TMO] && (to_lim != '0) && (to_cnt >= to_lim) && short_ok;

        why = RSN_NONE;
        if (fg_l2d && cond_en[CE_L2D])
            why = RSN_L2D;
        else if (fg_l2i && cond_en[CE_L2I])
            why = RSN_L2I;
        else if (fg_tlb && cond_en[CE_L2D])
            why = RSN_TLB;
        else if (short_ok && fg_l1d && cond_en[CE_L1D])
            why = RSN_L1D;
        else if (short_ok && fg_l1i && cond_en[CE_L1I])
            why = RSN_L1I;
        else if (short_ok && fg_xlat && cond_en[CE_XLAT])
            why = RSN_XLAT;
        else if (prio_back)
            why = RSN_PRIO;
        else if (tmo_hit)
            why = RSN_TIMEOUT;

        dec.why = why;
        dec.go  = bg_en && !busy && !(fp_fg > fp_lim) && (why != RSN_NONE);
    end

endmodule

// File: rtl/thread_switch_ctl.sv
module thread_switch_ctl
    import tsw_pkg::*;
#(
    parameter int TO_W = 16,
    parameter int FP_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      thr_en,
    input  logic [1:0]      prio_t0,
    input  logic [1:0]      prio_t1,
    input  logic [CE_W-1:0] cond_en,
    input  logic [TO_W-1:0] timeout_lim,
    input  logic [FP_W-1:0] fp_lim,
    input  logic [1:0]      ev_dmiss,
    input  logic [1:0]      ev_imiss,
    input  logic [1:0]      ev_xmiss,
    input  logic [1:0]      ev_l2d,
    input  logic [1:0]      ev_l2i,
    input  logic [1:0]      ev_tlb,
    input  logic [1:0]      ev_done,
    input  logic [1:0]      ev_retire,
    output logic            sw_req,
    output logic            active_thr,
    output logic [3:0]      reason_t0,
    output logic [3:0]      reason_t1
);
    localparam int NTHR = 2;

    logic            act, bg;
    logic [NTHR-1:0] long_w;
    logic [FP_W-1:0] fp_cnt [NTHR];
    logic [TO_W-1:0] to_cnt;
    logic [1:0]      prio [NTHR];
    rsn_e            rsn_q [NTHR];
    sw_dec_s         dec;

    assign bg      = ~act;
    assign prio[0] = prio_t0;
    assign prio[1] = prio_t1;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        tsw_thread_state #(.FP_W(FP_W)) u_state (
            .clk       (clk),
            .rst       (rst),
            .set_long  (any_long(ev_l2d[t], ev_l2i[t], ev_tlb[t])),
            .clr_long  (ev_done[t]),
            .bump      (sw_req),
            .retire    (ev_retire[t]),
            .long_wait (long_w[t]),
            .fp_cnt    (fp_cnt[t])
        );
    end

    tsw_timer #(.TO_W(TO_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (sw_req),
        .cnt (to_cnt)
    );

    tsw_decide #(.TO_W(TO_W), .FP_W(FP_W)) u_decide (
        .cond_en (cond_en),
        .bg_en   (thr_en[bg]),
        .prio_fg (prio[act]),
        .prio_bg (prio[bg]),
        .bg_long (long_w[bg]),
        .fg_l1d  (ev_dmiss[act]),
        .fg_l1i  (ev_imiss[act]),
        .fg_xlat (ev_xmiss[act]),
        .fg_l2d  (ev_l2d[act]),
        .fg_l2i  (ev_l2i[act]),
        .fg_tlb  (ev_tlb[act]),
        .bg_done (ev_done[bg]),
        .to_cnt  (to_cnt),
        .to_lim  (timeout_lim),
        .fp_fg   (fp_cnt[act]),
        .fp_lim  (fp_lim),
        .busy    (sw_req),
        .dec     (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_req   <= 1'b0;
            act      <= 1'b0;
            rsn_q[0] <= RSN_NONE;
            rsn_q[1] <= RSN_NONE;
        end else begin
            sw_req <= dec.go;
            if (dec.go)
                rsn_q[act] <= dec.why;
            if (sw_req)
                act <= ~act;
        end
    end

    assign active_thr = act;
    assign reason_t0  = rsn_q[0];
    assign reason_t1  = rsn_q[1];

    // R10: request lasts one cycle
    assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        sw_req |=> !sw_req);

    // R10: active thread flips right after a request
    assert_act_moves_R10: assert property (@(posedge clk) disable iff (rst)
        sw_req |=> act != $past(act));

    // R10: active thread holds without a request
    assert_act_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !sw_req |=> act == $past(act));

    // R10: active-cycle count restarts with the flip
    assert_tmr_restart_R10: assert property (@(posedge clk) disable iff (rst)
        sw_req |=> to_cnt == '0);

    // R9: never hand over to a disabled thread
    assert_no_dis_target_R9: assert property (@(posedge clk) disable iff (rst)
        (!thr_en[bg] && !sw_req) |=> !sw_req);

    // R6: forward-progress inhibit
    assert_fp_inhibit_R6: assert property (@(posedge clk) disable iff (rst)
        ((fp_cnt[act] > fp_lim) && !sw_req) |=> !sw_req);

endmodule

// File: tb/thread_switch_ctl_tb.sv
module thread_switch_ctl_tb;
    import tsw_pkg::*;

    localparam int K_DM = 0, K_IM = 1, K_XM = 2, K_L2D = 3, K_L2I = 4,
                   K_TLB = 5, K_DONE = 6, K_RET = 7, K_RETALL = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  thr_en, prio_t0, prio_t1;
    logic [6:0]  cond_en;
    logic [15:0] timeout_lim;
    logic [3:0]  fp_lim;
    logic [1:0]  ev_dmiss, ev_imiss, ev_xmiss, ev_l2d, ev_l2i, ev_tlb, ev_done, ev_retire;
    logic        sw_req, active_thr;
    logic [3:0]  reason_t0, reason_t1;

    always #5 clk = ~clk;

    thread_switch_ctl u_dut (
        .clk(clk), .rst(rst), .thr_en(thr_en), .prio_t0(prio_t0), .prio_t1(prio_t1),
        .cond_en(cond_en), .timeout_lim(timeout_lim), .fp_lim(fp_lim),
        .ev_dmiss(ev_dmiss), .ev_imiss(ev_imiss), .ev_xmiss(ev_xmiss),
        .ev_l2d(ev_l2d), .ev_l2i(ev_l2i), .ev_tlb(ev_tlb), .ev_done(ev_done),
        .ev_retire(ev_retire), .sw_req(sw_req), .active_thr(active_thr),
        .reason_t0(reason_t0), .reason_t1(reason_t1)
    );

    typedef struct {
        logic [3:0] rsn;
        logic       new_act;
        string      req;
    } exp_t;

    exp_t sbq[$];
    exp_t cur;
    int   n_chk = 0, n_fail = 0, n_pulse = 0, cyc = 0, last1 = 0, last2 = 0;
    bit   pend = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // monitor: pops the scoreboard on every request pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (pend) begin
                chk(active_thr == cur.new_act, cur.req, "active thread",
                    active_thr, cur.new_act);
                pend = 0;
            end
            if (sw_req) begin
                n_pulse++;
                last2 = last1;
                last1 = cyc;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected switch", 1, 0);
                end else begin
                    cur = sbq.pop_front();
                    chk((active_thr ? reason_t1 : reason_t0) == cur.rsn, cur.req, "reason",
                        active_thr ? reason_t1 : reason_t0, cur.rsn);
                    pend = 1;
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_ev();
        ev_dmiss = 0; ev_imiss = 0; ev_xmiss = 0; ev_l2d = 0;
        ev_l2i = 0; ev_tlb = 0; ev_done = 0; ev_retire = 0;
    endtask

    task automatic fire(input int k, input int t);
        case (k)
            K_DM:     ev_dmiss[t]  = 1'b1;
            K_IM:     ev_imiss[t]  = 1'b1;
            K_XM:     ev_xmiss[t]  = 1'b1;
            K_L2D:    ev_l2d[t]    = 1'b1;
            K_L2I:    ev_l2i[t]    = 1'b1;
            K_TLB:    ev_tlb[t]    = 1'b1;
            K_DONE:   ev_done[t]   = 1'b1;
            K_RET:    ev_retire[t] = 1'b1;
            default:  ev_retire    = 2'b11;
        endcase
        tick(1);
        clear_ev();
    endtask

    task automatic expect_sw(input logic [3:0] rsn, input logic new_act, input string req);
        exp_t e;
        e.rsn = rsn; e.new_act = new_act; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic drain(input string req);
        tick(6);
        chk(sbq.size() == 0, req, "switches still pending", sbq.size(), 0);
    endtask

    task automatic quiet(input int base, input string req);
        tick(6);
        chk(n_pulse == base, req, "switch count", n_pulse, base);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int base;
        rst = 1'b1; clear_ev();
        thr_en = 2'b11; prio_t0 = 2'd1; prio_t1 = 2'd1;
        cond_en = 7'h7f; timeout_lim = '0; fp_lim = 4'd15;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk(active_thr == 1'b0, "R1", "reset active", active_thr, 0);
        chk(sw_req == 1'b0, "R1", "reset request", sw_req, 0);
        chk(reason_t0 == 4'd0, "R1", "reset reason t0", reason_t0, 0);
        chk(reason_t1 == 4'd0, "R1", "reset reason t1", reason_t1, 0);

        // R2: short misses with an idle background thread
        expect_sw(4'd1, 1'b1, "R2"); fire(K_DM, 0); drain("R2");
        expect_sw(4'd2, 1'b0, "R2"); fire(K_IM, 1); drain("R2");

        // R3: background thread stalled on a TLB miss blocks short-miss switch
        fire(K_TLB, 1);
        base = n_pulse; fire(K_XM, 0); quiet(base, "R3");

        // R4: a long miss switches anyway
        expect_sw(4'd5, 1'b1, "R4"); fire(K_L2I, 0); drain("R4");
        fire(K_DONE, 0); fire(K_DONE, 1); tick(2);

        // R8: masked data-miss trigger, then unmasked
        cond_en[0] = 1'b0;
        base = n_pulse; fire(K_DM, 1); quiet(base, "R8");
        cond_en = 7'h7f;
        expect_sw(4'd1, 1'b0, "R8"); fire(K_DM, 1); drain("R8");

        // R9: single-thread operation
        thr_en = 2'b01;
        base = n_pulse; fire(K_L2D, 0); quiet(base, "R9");
        fire(K_DONE, 0); thr_en = 2'b11; tick(2);

        // R5: forced switches on the cycle budget
        expect_sw(4'd7, 1'b1, "R5");
        expect_sw(4'd7, 1'b0, "R5");
        expect_sw(4'd7, 1'b1, "R5");
        timeout_lim = 16'd5;
        while (sbq.size() != 0) tick(1);
        timeout_lim = '0;
        chk(last1 - last2 == 7, "R5", "timeout spacing", last1 - last2, 7);
        tick(3);

        // R6: forward-progress inhibit and release
        fire(K_RETALL, 0);
        fp_lim = 4'd1;
        expect_sw(4'd1, 1'b0, "R6"); fire(K_DM, 1); drain("R6");
        expect_sw(4'd1, 1'b1, "R6"); fire(K_DM, 0); drain("R6");
        base = n_pulse; fire(K_DM, 1); quiet(base, "R6");
        fire(K_RET, 1);
        expect_sw(4'd1, 1'b0, "R6"); fire(K_DM, 1); drain("R6");
        fp_lim = 4'd15; fire(K_RETALL, 0);

        // R7: unequal priorities, thread 0 more important and active
        prio_t0 = 2'd2; prio_t1 = 2'd1;
        base = n_pulse; fire(K_DM, 0); quiet(base, "R7");
        expect_sw(4'd4, 1'b1, "R7"); fire(K_L2D, 0); drain("R7");
        expect_sw(4'd8, 1'b0, "R7"); fire(K_DONE, 0); drain("R7");

        tick(4);
        summary();
        $finish;
    end

endmodule